// File: doc/BRIEF.md
# Three-Read One-Write Register File

This block holds the general-purpose registers of a small pipelined processor. In every clock cycle it can return three operands, on ports A, B and D, and accept one new register value. It is made of three copies of a dual-port memory. Each copy feeds one read port. Every write goes to all three copies, so the copies always hold the same contents.

Reads are synchronous. The decode stage presents each read address one cycle early, using the value that is about to be registered. The data then appears on the read outputs after the next enabled clock edge, in the same cycle as the registered decode fields. A write takes effect when its strobe is high. If a read address matches the write address in the same enabled cycle, the read returns the new value.

A single clock enable stalls the whole block. Register 0 is hard-wired to zero.

Top module: `regfile3r1w`

## Requirements
- R1: The three read ports are independent: after an enabled clock edge, each of `rd_data_a`, `rd_data_b` and `rd_data_d` holds the contents of the register whose address was on its own address input at that edge.
- R2: A register is written with `wr_data` at an enabled edge only when `wr_en` is 1. With `wr_en` at 0 the contents stay unchanged, which a later read shows.
- R3: When a read address equals `wr_addr` at an enabled edge with `wr_en` at 1 and a nonzero address, that read port returns the new `wr_data` and not the old contents.
- R4: Register address 0 always reads as zero on every port. A write to address 0 is discarded, even when it collides with a read of address 0.
- R5: While `en` is 0, all three outputs hold their values and no write takes place, whatever `wr_en` carries.
- R6: While `rst` is 1 at a clock edge, all three read outputs become zero, whatever the value of `en`.
- R7: Addresses are `ADDR_W` bits wide, giving 2**ADDR_W registers (default 5 bits, 32 registers). The data width is `DATA_W` (default 32 bits), and all bits up to the top one are stored and returned.
- R8: All copies receive the same write. When all three ports read the same address at an enabled edge, the three outputs are equal afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the read outputs |
| en | input | 1 | Clock enable for reads and writes |
| rd_addr_a | input | ADDR_W | Next-cycle read address, port A |
| rd_addr_b | input | ADDR_W | Next-cycle read address, port B |
| rd_addr_d | input | ADDR_W | Next-cycle read address, port D |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data_a | output | DATA_W | Read data, port A |
| rd_data_b | output | DATA_W | Read data, port B |
| rd_data_d | output | DATA_W | Read data, port D |

## Verification
The assertions assume that no register other than 0 is read before it has been written. The memory copies have no reset, so such a read returns unknown data. The bench therefore loads every register from 1 upward before any read that is not a collision or an address-0 read.

The assertions also assume that inputs are stable around each clock edge. The bench changes them only a short time after a rising edge. While `en` is low, it drives writes and new addresses only to show that they have no effect, and it makes no assumption about their values.

// File: rtl/regfile3r1w.sv
module regfile3r1w #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] rd_addr_d,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  output logic [DATA_W-1:0] rd_data_d
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int NPORT = 3;

  logic [ADDR_W-1:0] raddr [NPORT];
  logic [DATA_W-1:0] rdata [NPORT];
  logic              wr_go;

  assign raddr[0]  = rd_addr_a;
  assign raddr[1]  = rd_addr_b;
  assign raddr[2]  = rd_addr_d;
  assign rd_data_a = rdata[0];
  assign rd_data_b = rdata[1];
  assign rd_data_d = rdata[2];

  // writes to register 0 are dropped here, not left to the caller
  assign wr_go = en && wr_en && (wr_addr != '0);

  for (genvar g = 0; g < NPORT; g++) begin : g_copy
    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
      if (!rst && wr_go) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst)
        rdata[g] <= '0;
      else if (en) begin
        if (raddr[g] == '0)
          rdata[g] <= '0;
        else if (wr_en && wr_addr == raddr[g])
          rdata[g] <= wr_data;
        else
          rdata[g] <= mem[raddr[g]];
      end
    end

    assert_raw_R3: assert property (@(posedge clk) disable iff (rst)
      (en && wr_en && wr_addr == raddr[g] && wr_addr != '0) |=> rdata[g] == $past(wr_data));

    assert_zero_reg_R4: assert property (@(posedge clk) disable iff (rst)
      (en && raddr[g] == '0) |=> rdata[g] == '0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(rdata[g]));

    logic rst_q = 1'b0;
    always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q) assert_reset_R6: assert (rdata[g] == '0);
    end
  end

  assert_agree_R8: assert property (@(posedge clk) disable iff (rst)
    (en && rd_addr_a == rd_addr_b && rd_addr_b == rd_addr_d)
      |=> (rd_data_a == rd_data_b && rd_data_b == rd_data_d));
endmodule

// File: tb/regfile3r1w_tb_top.sv
module regfile3r1w_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, rd_addr_d = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rd_data_a, rd_data_b, rd_data_d;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [32];
  logic [31:0] exp_a = '0, exp_b = '0, exp_d = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile3r1w dut_i (
    .clk(clk), .rst(rst), .en(en),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_addr_d(rd_addr_d),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_d(rd_data_d)
  );

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  function automatic logic [31:0] predict(bit e, bit we, logic [4:0] wa, logic [31:0] wd,
                                          logic [4:0] ra, logic [31:0] prev);
    if (!e) return prev;
    if (ra == 5'd0) return '0;
    if (we && wa == ra) return wd;
    return model[ra];
  endfunction

  task automatic step(string rq, bit e, bit we, logic [4:0] wa, logic [31:0] wd,
                      logic [4:0] aa, logic [4:0] ab, logic [4:0] ad);
    logic [31:0] na, nb, nd;
    en = e; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_addr_a = aa; rd_addr_b = ab; rd_addr_d = ad;
    na = predict(e, we, wa, wd, aa, exp_a);
    nb = predict(e, we, wa, wd, ab, exp_b);
    nd = predict(e, we, wa, wd, ad, exp_d);
    @(posedge clk);
    if (e && we && wa != 5'd0) model[wa] = wd;
    #1;
    exp_a = na; exp_b = nb; exp_d = nd;
    check(rq, "port A", rd_data_a, exp_a);
    check(rq, "port B", rd_data_b, exp_b);
    check(rq, "port D", rd_data_d, exp_d);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic t_reset_r6;
    rst = 1'b1; en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R6", "reset A", rd_data_a, '0);
    check("R6", "reset B", rd_data_b, '0);
    check("R6", "reset D", rd_data_d, '0);
    rst = 1'b0;
    exp_a = '0; exp_b = '0; exp_d = '0;
  endtask

  // fill every register; port A collides with the write, B reads 0, D reads the previous one
  task automatic t_fill_r2;
    for (int i = 1; i < 32; i++)
      step("R2/R3", 1, 1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 5'(i), 5'd0, 5'(i-1));
  endtask

  task automatic t_three_reads_r1;
    step("R1", 1, 0, 5'd0, '0, 5'd3, 5'd17, 5'd31);
    step("R1", 1, 0, 5'd0, '0, 5'd30, 5'd1, 5'd12);
    step("R1", 1, 0, 5'd0, '0, 5'd8, 5'd9, 5'd10);
  endtask

  task automatic t_collide_r3;
    step("R3", 1, 1, 5'd5, 32'h11112222, 5'd5, 5'd6, 5'd7);
    step("R3", 1, 1, 5'd6, 32'h33334444, 5'd5, 5'd6, 5'd7);
    step("R3", 1, 1, 5'd7, 32'h55556666, 5'd5, 5'd6, 5'd7);
    step("R3", 1, 0, 5'd0, '0, 5'd7, 5'd5, 5'd6);
  endtask

  task automatic t_strobe_low_r2;
    step("R2", 1, 0, 5'd9, 32'hDEADBEEF, 5'd9, 5'd9, 5'd1);
    step("R2", 1, 0, 5'd0, '0, 5'd9, 5'd2, 5'd9);
  endtask

  task automatic t_zero_r4;
    step("R4", 1, 1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0, 5'd0);
    step("R4", 1, 0, 5'd0, '0, 5'd0, 5'd0, 5'd0);
  endtask

  task automatic t_enable_r5;
    step("R5", 1, 0, 5'd0, '0, 5'd4, 5'd11, 5'd20);
    step("R5", 0, 1, 5'd4, 32'hCAFEF00D, 5'd4, 5'd22, 5'd23);
    step("R5", 0, 1, 5'd11, 32'h0BADC0DE, 5'd1, 5'd2, 5'd3);
    step("R5", 1, 0, 5'd0, '0, 5'd4, 5'd11, 5'd4);
  endtask

  task automatic t_width_r7;
    step("R7", 1, 1, 5'd31, 32'h80000001, 5'd30, 5'd29, 5'd28);
    step("R7", 1, 0, 5'd0, '0, 5'd31, 5'd31, 5'd30);
  endtask

  task automatic t_agree_r8;
    step("R8", 1, 1, 5'd14, 32'h7E57C0DE, 5'd14, 5'd14, 5'd14);
    step("R8", 1, 0, 5'd0, '0, 5'd14, 5'd14, 5'd14);
  endtask

  task automatic t_reset_again_r6;
    rst = 1'b1; en = 1'b1;
    @(posedge clk); #1;
    check("R6", "mid reset A", rd_data_a, '0);
    check("R6", "mid reset B", rd_data_b, '0);
    check("R6", "mid reset D", rd_data_d, '0);
    rst = 1'b0;
    exp_a = '0; exp_b = '0; exp_d = '0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    #1;
    t_reset_r6();
    t_fill_r2();
    t_three_reads_r1();
    t_collide_r3();
    t_strobe_low_r2();
    t_zero_r4();
    t_enable_r5();
    t_width_r7();
    t_agree_r8();
    t_reset_again_r6();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule